// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Redirection Table

This block is the software-facing register file of an I/O interrupt controller. The bus reaches it through two offsets only. The first holds an 8-bit select value. The second is a 32-bit data window onto whichever internal register the select value names. Behind the window are:

- a 4-bit controller identifier;
- a fixed version word that also reports the pin count;
- an arbitration word that is always zero;
- one 64-bit routing entry per interrupt pin, reached as two 32-bit halves.

Every routing entry is presented in parallel to the interrupt service engine. That engine sets and clears each entry's remote-pending flag with per-pin strobes. After each software update of a routing entry, the block emits a one-cycle "table changed" pulse, so that the engine can re-evaluate pending pins. Reads return data one clock after the request. Reset leaves every pin masked.

Top module: `intc_regwin`

## Requirements
- R1: The offset decoder sees 8 bits. Offset 0x00 writes the select register from data bits 7:0 at any access size. A read of offset 0x00 returns the select value zero-extended. Any offset other than 0x00 and 0x10 reads as zero and ignores writes.
- R2: A data-window (offset 0x10) access whose byte count `bus_size_i` is not 4 is ignored. A write has no effect and a read returns zero.
- R3: With select 0x00, a window write stores data bits 27:24 as the identifier. A window read returns the identifier in bits 27:24 and zeros elsewhere.
- R4: With select 0x01, a window read returns 0x11 in bits 7:0 and (NUM_PINS − 1) in bits 23:16. Writes to it change nothing.
- R5: With select 0x02, a window read returns zero and writes change nothing.
- R6: For selects of 0x10 and above, the entry index is (select − 0x10) >> 1. An even select reaches entry bits 31:0 and an odd select reaches bits 63:32. A write to one half leaves the other half unchanged.
- R7: Selects 0x03 to 0x0F, and selects whose entry index is NUM_PINS or more, read as zero. Writes through them change no entry and raise no pulse.
- R8: `tbl_chg_o` is high for exactly the one cycle after a full-word window write to an in-range entry half. It is low otherwise.
- R9: After reset the identifier is 0 and the select is 0. Every entry holds only bit 16 (the mask bit), that is 0x0000_0000_0001_0000. `tbl_chg_o` is 0.
- R10: Entry bit 14 (remote pending) changes only through `rirr_set_i` and `rirr_clr_i`, and takes effect one cycle after the strobe. Set wins when both strobes are high. A software write to the low half keeps the stored bit 14 whatever the data bit holds.
- R11: `bus_rdata_o` is registered. It carries the read result in the cycle after `bus_rd_i` is sampled, and is zero after a cycle with no read. A read issued in the same cycle as a write returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Write request |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | 8 | Register offset |
| bus_size_i | input | 3 | Access size in bytes |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the request |
| rirr_set_i | input | NUM_PINS | Per-pin remote-pending set strobes |
| rirr_clr_i | input | NUM_PINS | Per-pin remote-pending clear strobes |
| tbl_chg_o | output | 1 | One-cycle pulse after a routing entry write |
| entries_o | output | NUM_PINS*64 | All routing entries, pin i at bits 64*i+63 : 64*i |

## Verification
The results fall due at different times:

- **Read data** is due one cycle after the read is sampled. The bench drives each request on a falling edge and queues the expected word at that moment. A monitor records which rising edges took a read, and pops and compares the queued word on the following falling edge.
- **Entry contents, remote-pending updates and the change pulse** are due in the cycle after the write or strobe is sampled. The bench compares them on the falling edge that closes the access.
- **Absence of the pulse** is checked one further falling edge later.

Entry contents, remote-pending state and the pulse are compared against `entries_o` and `tbl_chg_o`.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int          ENT_W      = 64;
  localparam int          WORD_W     = 32;
  localparam int          MASK_BIT   = 16;
  localparam int          RPEND_BIT  = 14;
  localparam logic [7:0]  VER_CODE   = 8'h11;
  localparam logic [7:0]  OFS_SEL    = 8'h00;
  localparam logic [7:0]  OFS_WIN    = 8'h10;
  localparam logic [7:0]  SEL_IDENT  = 8'h00;
  localparam logic [7:0]  SEL_VER    = 8'h01;
  localparam logic [7:0]  SEL_ARB    = 8'h02;
  localparam logic [7:0]  SEL_TBL0   = 8'h10;
  localparam logic [2:0]  FULL_WORD  = 3'd4;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SEL,
    TGT_IDENT,
    TGT_VER,
    TGT_ARB,
    TGT_ENT
  } tgt_e;
endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
  import regwin_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = 5
) (
  input  logic [7:0]       addr_i,
  input  logic [2:0]       size_i,
  input  logic [7:0]       sel_i,
  output tgt_e             tgt_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             hi_o
);
  logic [7:0] rel;
  logic [6:0] idx_full;

  assign rel      = sel_i - SEL_TBL0;
  assign idx_full = rel[7:1];
  assign hi_o     = sel_i[0];
  assign idx_o    = idx_full[IDX_W-1:0];

  always_comb begin
    tgt_o = TGT_NONE;
    if (addr_i == OFS_SEL) begin
      tgt_o = TGT_SEL;
    end else if (addr_i == OFS_WIN && size_i == FULL_WORD) begin
      if (sel_i == SEL_IDENT)      tgt_o = TGT_IDENT;
      else if (sel_i == SEL_VER)   tgt_o = TGT_VER;
      else if (sel_i == SEL_ARB)   tgt_o = TGT_ARB;
      else if (sel_i >= SEL_TBL0 && int'(idx_full) < NUM_PINS)
        tgt_o = TGT_ENT;
    end
  end
endmodule

// File: rtl/regwin_entry.sv
module regwin_entry
  import regwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              set_i,
  input  logic              clr_i,
  output logic [ENT_W-1:0]  q_o
);
  localparam logic [WORD_W-1:0] RP_M  = WORD_W'(1) << RPEND_BIT;
  localparam logic [ENT_W-1:0]  RST_V = ENT_W'(1) << MASK_BIT;

  logic [ENT_W-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_V;
    end else begin
      if (wr_lo_i) q[WORD_W-1:0] <= (wdata_i & ~RP_M) | (q[WORD_W-1:0] & RP_M);
      if (wr_hi_i) q[ENT_W-1:WORD_W] <= wdata_i;
      if (set_i)      q[RPEND_BIT] <= 1'b1;
      else if (clr_i) q[RPEND_BIT] <= 1'b0;
    end
  end

  assign q_o = q;

  p_rpend_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(q_o[RPEND_BIT]));
  p_rpend_set_r10: assert property (@(posedge clk) disable iff (rst)
    set_i |=> q_o[RPEND_BIT]);
  p_rpend_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !q_o[RPEND_BIT]);
  p_hi_kept_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_hi_i |=> $stable(q_o[ENT_W-1:WORD_W]));
endmodule

// File: rtl/intc_regwin.sv
module intc_regwin
  import regwin_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_wr_i,
  input  logic                      bus_rd_i,
  input  logic [7:0]                bus_addr_i,
  input  logic [2:0]                bus_size_i,
  input  logic [WORD_W-1:0]         bus_wdata_i,
  output logic [WORD_W-1:0]         bus_rdata_o,
  input  logic [NUM_PINS-1:0]       rirr_set_i,
  input  logic [NUM_PINS-1:0]       rirr_clr_i,
  output logic                      tbl_chg_o,
  output logic [NUM_PINS*ENT_W-1:0] entries_o
);
  localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [WORD_W-1:0] VER_WORD =
    WORD_W'(VER_CODE) | (WORD_W'(NUM_PINS - 1) << 16);

  logic [7:0]        sel_q;
  logic [3:0]        ident_q;
  logic [WORD_W-1:0] rdata_q;
  logic              chg_q;
  tgt_e              tgt;
  logic [IDX_W-1:0]  idx;
  logic              hi;
  logic [NUM_PINS-1:0] wr_lo, wr_hi;
  logic [ENT_W-1:0]  ent [NUM_PINS];
  logic [WORD_W-1:0] rd_val;
  logic              ent_wr;

  regwin_decode #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_dec (
    .addr_i(bus_addr_i), .size_i(bus_size_i), .sel_i(sel_q),
    .tgt_o(tgt), .idx_o(idx), .hi_o(hi)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    assign wr_lo[i] = bus_wr_i && tgt == TGT_ENT && idx == IDX_W'(i) && !hi;
    assign wr_hi[i] = bus_wr_i && tgt == TGT_ENT && idx == IDX_W'(i) && hi;
    regwin_entry u_ent (
      .clk(clk), .rst(rst), .wr_lo_i(wr_lo[i]), .wr_hi_i(wr_hi[i]),
      .wdata_i(bus_wdata_i), .set_i(rirr_set_i[i]), .clr_i(rirr_clr_i[i]),
      .q_o(ent[i])
    );
    assign entries_o[i*ENT_W +: ENT_W] = ent[i];
  end

  assign ent_wr = |{wr_lo, wr_hi};

  always_comb begin
    rd_val = '0;
    case (tgt)
      TGT_SEL:   rd_val = WORD_W'(sel_q);
      TGT_IDENT: rd_val = WORD_W'(ident_q) << 24;
      TGT_VER:   rd_val = VER_WORD;
      TGT_ENT: begin
        for (int i = 0; i < NUM_PINS; i++)
          if (idx == IDX_W'(i))
            rd_val = hi ? ent[i][ENT_W-1:WORD_W] : ent[i][WORD_W-1:0];
      end
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      ident_q <= '0;
      rdata_q <= '0;
      chg_q   <= 1'b0;
    end else begin
      rdata_q <= bus_rd_i ? rd_val : '0;
      chg_q   <= ent_wr;
      if (bus_wr_i && tgt == TGT_SEL)   sel_q   <= bus_wdata_i[7:0];
      if (bus_wr_i && tgt == TGT_IDENT) ident_q <= bus_wdata_i[27:24];
    end
  end

  assign bus_rdata_o = rdata_q;
  assign tbl_chg_o   = chg_q;

  p_one_half_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_lo, wr_hi}));
  p_chg_cause_r8: assert property (@(posedge clk) disable iff (rst)
    tbl_chg_o |-> $past(bus_wr_i && bus_addr_i == OFS_WIN && bus_size_i == FULL_WORD));
  p_short_read_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == OFS_WIN && bus_size_i != FULL_WORD) |=> bus_rdata_o == '0);
  p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> bus_rdata_o == '0);
  p_sel_echo_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && bus_addr_i == OFS_SEL) |=> bus_rdata_o == WORD_W'($past(sel_q)));
endmodule

// File: tb/intc_regwin_tb_top.sv
module intc_regwin_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;

  logic clk = 0, rst = 1;
  logic wr = 0, rd = 0;
  logic [7:0] addr = 0;
  logic [2:0] size = 4;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [NP-1:0] rset = '0, rclr = '0;
  logic chg;
  logic [NP*64-1:0] ents;

  int compared = 0, mismatched = 0;
  bit pend = 0, done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  intc_regwin #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_size_i(size), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rirr_set_i(rset), .rirr_clr_i(rclr), .tbl_chg_o(chg), .entries_o(ents)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= rd && !rst;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(rdata === e, t, 64'(rdata), 64'(e));
    end
  end

  task automatic bwrite(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; size = sz; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic bread(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] e, input string t);
    @(negedge clk); rd = 1; addr = a; size = sz;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 0;
  endtask

  task automatic pick(input logic [7:0] s);
    bwrite(8'h00, 3'd4, {24'h0, s});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    compared++; mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    check(chg === 1'b0, "R9 pulse", 64'(chg), 64'h0);
    check(ents[63:0] === 64'h10000, "R9 entry0", ents[63:0], 64'h10000);
    check(ents[23*64 +: 64] === 64'h10000, "R9 entry23", ents[23*64 +: 64], 64'h10000);
    bread(8'h00, 3'd4, 32'h0, "R9 select");
    bread(8'h10, 3'd4, 32'h0, "R9 ident");
    // R11 idle zero
    @(negedge clk);
    check(rdata === 32'h0, "R11 idle", 64'(rdata), 64'h0);
    // R4 version
    pick(8'h01);
    bread(8'h00, 3'd1, 32'h01, "R1 select echo");
    bread(8'h10, 3'd4, 32'h00170011, "R4 version");
    bwrite(8'h10, 3'd4, 32'hFFFFFFFF);
    bread(8'h10, 3'd4, 32'h00170011, "R4 version after write");
    // R3 ident, R2 size
    pick(8'h00);
    bwrite(8'h10, 3'd4, 32'hAB00FFFF);
    bread(8'h10, 3'd4, 32'h0B000000, "R3 ident");
    bwrite(8'h10, 3'd2, 32'h05000000);
    bread(8'h10, 3'd4, 32'h0B000000, "R2 short write ignored");
    bread(8'h10, 3'd2, 32'h0, "R2 short read zero");
    // R5 arbitration
    pick(8'h02);
    bwrite(8'h10, 3'd4, 32'h0F000000);
    bread(8'h10, 3'd4, 32'h0, "R5 arb");
    // R6 halves, R8 pulse
    pick(8'h10);
    bwrite(8'h10, 3'd4, 32'h0000A031);
    check(chg === 1'b1, "R8 pulse high", 64'(chg), 64'h1);
    @(negedge clk);
    check(chg === 1'b0, "R8 pulse one cycle", 64'(chg), 64'h0);
    pick(8'h11);
    bwrite(8'h10, 3'd4, 32'h5A000000);
    check(ents[63:0] === 64'h5A000000_0000A031, "R6 entry0 both halves", ents[63:0], 64'h5A000000_0000A031);
    bread(8'h10, 3'd4, 32'h5A000000, "R6 high read");
    pick(8'h10);
    bread(8'h10, 3'd4, 32'h0000A031, "R6 low kept");
    bwrite(8'h10, 3'd2, 32'h1);
    check(chg === 1'b0, "R8 no pulse on short write", 64'(chg), 64'h0);
    // R6 last entry high half
    pick(8'h3F);
    bwrite(8'h10, 3'd4, 32'h12345678);
    check(ents[23*64 +: 64] === 64'h12345678_00010000, "R6 entry23", ents[23*64 +: 64], 64'h12345678_00010000);
    bread(8'h10, 3'd4, 32'h12345678, "R6 entry23 read");
    // R7 out of range
    pick(8'h40);
    bwrite(8'h10, 3'd4, 32'hFFFFFFFF);
    check(chg === 1'b0, "R7 no pulse", 64'(chg), 64'h0);
    bread(8'h10, 3'd4, 32'h0, "R7 beyond table");
    pick(8'h05);
    bread(8'h10, 3'd4, 32'h0, "R7 gap select");
    bread(8'h04, 3'd4, 32'h0, "R1 other offset");
    bwrite(8'h20, 3'd4, 32'h11);
    bread(8'h00, 3'd4, 32'h05, "R1 other offset write ignored");
    // R10 remote pending
    @(negedge clk); rset[0] = 1;
    @(negedge clk); rset[0] = 0;
    check(ents[14] === 1'b1, "R10 set", 64'(ents[14]), 64'h1);
    pick(8'h10);
    bread(8'h10, 3'd4, 32'h0000E031, "R10 read set");
    bwrite(8'h10, 3'd4, 32'h00000031);
    bread(8'h10, 3'd4, 32'h00004031, "R10 write keeps set");
    pick(8'h12);
    bwrite(8'h10, 3'd4, 32'h0000FFFF);
    bread(8'h10, 3'd4, 32'h0000BFFF, "R10 write keeps clear");
    @(negedge clk); rset[0] = 1; rclr[0] = 1;
    @(negedge clk); rset[0] = 0; rclr[0] = 0;
    check(ents[14] === 1'b1, "R10 set wins", 64'(ents[14]), 64'h1);
    @(negedge clk); rclr[0] = 1;
    @(negedge clk); rclr[0] = 0;
    check(ents[31:0] === 32'h00000031, "R10 clear", 64'(ents[31:0]), 64'h31);
    // R11 read during write returns old value
    pick(8'h10);
    @(negedge clk); wr = 1; rd = 1; addr = 8'h10; size = 3'd4; wdata = 32'h77;
    exp_q.push_back(32'h00000031); tag_q.push_back("R11 read with write");
    @(negedge clk); wr = 0; rd = 0;
    bread(8'h10, 3'd4, 32'h00000077, "R11 new value");
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule